// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Clear Unit

This block sits between an I2C controller's protocol engine and the processor's register bus. It gathers twelve controller events into a raw status word and applies a software mask to form an enabled status word. It drives one interrupt line that is high whenever any enabled event is pending. Most events are sticky. Two of them, the receive-level and transmit-level indications, follow their queue-threshold inputs directly.

Software clears events by reading, not by writing. Each sticky event has its own clear address, so an interrupt handler can acknowledge exactly the events it has seen without losing one that arrives in the same cycle. A single global clear address exists for initialisation. When the protocol engine aborts a transfer, it presents a cause vector with its abort event, and the unit accumulates that vector in an abort-cause register. Only the abort event's own clear address empties that register.

The unit also holds the controller enable bit and reports, through a separate enable-status bit, when the controller has actually changed state. Enabling takes effect on the next cycle. Disabling waits for a byte in flight to finish, but never longer than a parameterised number of cycles.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: Raw status (address 0x00) holds the events at these bit positions: receive underflow 0, receive overflow 1, receive level 2, transmit overflow 3, transmit level 4, read request 5, transfer abort 6, receive done 7, activity 8, stop seen 9, start seen 10, general call 11. Bits 2 and 4 reflect `evt_in[2]` and `evt_in[4]` in the same cycle, and no read clears them.
- R2: Every other event sets its raw bit on the clock edge after a one-cycle pulse on its `evt_in` bit, and the bit stays set until it is cleared. A pulse in the same cycle as a clear of that bit leaves the bit set.
- R3: The mask register (address 0x04, bits 11:0, reset 0) is written through the register port. Address 0x08 reads raw AND mask. `irq` is high exactly when that AND is nonzero.
- R4: Reading address 0x40 + 4*n returns raw bit n in bit 0. For a sticky event, that read clears raw bit n on the following edge and leaves every other bit unchanged.
- R5: Reading address 0x0C returns in bit 0 whether any sticky bit is set, and clears all sticky bits on the following edge.
- R6: On an abort pulse (`evt_in[6]`), the abort-cause register (address 0x10) ORs in `abrt_cause`, keeping only bits 0–5, 7, 9, 10 and 11. Bits 6, 8 and 12 and above always read 0. The valid bits mean: 7-bit address NACK 0, first 10-bit address byte NACK 1, second 10-bit address byte NACK 2, data NACK 3, general call NACK 4, read after general call 5, start byte acknowledged 7, start byte with restart off 9, 10-bit read with restart off 10, and disabled controller used 11.
- R7: Only a read of the abort clear address 0x58 empties the abort-cause register, on the following edge. Global clear and all other reads leave it unchanged. A cause captured in the same cycle as the clear is kept.
- R8: Writing 1 to bit 0 of address 0x14 requests enable. The enable-status bit (address 0x18 bit 0 and `ctl_enabled`) rises on the edge after the request becomes visible.
- R9: After the enable request is cleared, the enable status falls on the first edge at which `byte_busy` is low. If `byte_busy` stays high, it falls on the DRAIN_MAX-th edge after the request was cleared.
- R10: Address 0x1C bit 0 reads `bus_active`. Address 0x20 reads the constant 0x44570140.
- R11: Reads of any address other than the clear addresses change no state. Writes to addresses other than 0x04 and 0x14 are ignored. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_rd | input | 1 | Read strobe; clear side effects occur on this cycle's edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the same cycle |
| evt_in | input | 12 | Event pulses; bits 2 and 4 are levels |
| abrt_cause | input | 12 | Abort cause vector, sampled with `evt_in[6]` |
| bus_active | input | 1 | Bus activity from the protocol engine |
| byte_busy | input | 1 | A byte is in flight |
| ctl_enabled | output | 1 | Enable status |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets collisions between a clear read and a new event or abort cause in the same cycle. A design that lets the clear win would lose that event: the raw bit would drop, or the abort register would come back empty. It also reads the level bits' clear addresses and uses global clear while an abort cause is held. A decoder that treats these like ordinary sticky bits would clear a level it cannot own, or erase the abort cause early. The enable handshake is run with `byte_busy` low, held high past the drain limit, and dropped partway through. An off-by-one drain counter or an immediate status update would show up as `ctl_enabled` changing one or more cycles from the expected edge.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  localparam int NUM_EVT = 12;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  // event bit positions
  localparam int EV_RX_UNDER = 0;
  localparam int EV_RX_OVER  = 1;
  localparam int EV_RX_LVL   = 2;
  localparam int EV_TX_OVER  = 3;
  localparam int EV_TX_LVL   = 4;
  localparam int EV_RD_REQ   = 5;
  localparam int EV_ABORT    = 6;
  localparam int EV_RX_DONE  = 7;
  localparam int EV_ACTIVITY = 8;
  localparam int EV_STOP     = 9;
  localparam int EV_START    = 10;
  localparam int EV_GCALL    = 11;

  localparam logic [NUM_EVT-1:0] LEVEL_MASK = 12'h014;
  localparam logic [NUM_EVT-1:0] ABRT_VALID = 12'hEBF;

  localparam logic [ADDR_W-1:0] A_RAW     = 8'h00;
  localparam logic [ADDR_W-1:0] A_MASK    = 8'h04;
  localparam logic [ADDR_W-1:0] A_STAT    = 8'h08;
  localparam logic [ADDR_W-1:0] A_CLR_ALL = 8'h0C;
  localparam logic [ADDR_W-1:0] A_ABRT    = 8'h10;
  localparam logic [ADDR_W-1:0] A_EN      = 8'h14;
  localparam logic [ADDR_W-1:0] A_EN_ST   = 8'h18;
  localparam logic [ADDR_W-1:0] A_BUS     = 8'h1C;
  localparam logic [ADDR_W-1:0] A_ID      = 8'h20;
  localparam int                A_CLR_BASE = 'h40;

  localparam logic [DATA_W-1:0] COMP_ID = 32'h44570140;

endpackage

// File: rtl/i2c_irq_evt_bank.sv
module i2c_irq_evt_bank
  import i2c_irq_pkg::*;
#(
  parameter int               N   = NUM_EVT,
  parameter logic [N-1:0]     LVL = LEVEL_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] clr,
  output logic [N-1:0] raw
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (LVL[i]) begin : g_lvl
      assign raw[i] = src[i];
    end else begin : g_stk
      logic q;
      logic ce;
      logic d;
      // set has priority: a pulse together with a clear keeps the bit
      assign ce = src[i] | clr[i];
      assign d  = src[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (ce) q <= d;
      end
      assign raw[i] = q;
    end
  end

  logic unused_lvl_clr;
  assign unused_lvl_clr = ^(clr & LVL);

endmodule

// File: rtl/i2c_irq_abort_rec.sv
module i2c_irq_abort_rec
  import i2c_irq_pkg::*;
#(
  parameter int           N     = NUM_EVT,
  parameter logic [N-1:0] VALID = ABRT_VALID
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [N-1:0] cause,
  input  logic         clr,
  output logic [N-1:0] src
);

  logic [N-1:0] q;
  logic [N-1:0] d;
  logic         ce;

  always_comb begin
    d = clr ? '0 : q;
    if (capture) d = d | (cause & VALID);
  end

  assign ce = capture | clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ce) q <= d;
  end

  assign src = q;

  logic unused_rsvd;
  assign unused_rsvd = ^(cause & ~VALID);

endmodule

// File: rtl/i2c_irq_en_ctrl.sv
module i2c_irq_en_ctrl #(
  parameter int DRAIN_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic byte_busy,
  output logic en_stat
);

  localparam int              CNT_W    = (DRAIN_MAX > 1) ? $clog2(DRAIN_MAX) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRAIN_MAX - 1);

  logic             stat_q, stat_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    stat_d = stat_q;
    cnt_d  = '0;
    if (en_req && !stat_q) begin
      stat_d = 1'b1;
    end else if (!en_req && stat_q) begin
      if (!byte_busy || (cnt_q == CNT_LAST)) stat_d = 1'b0;
      else                                    cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      stat_q <= stat_d;
      cnt_q  <= cnt_d;
    end
  end

  assign en_stat = stat_q;

endmodule

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
  import i2c_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_EVT-1:0] raw,
  input  logic [NUM_EVT-1:0] abrt,
  input  logic               en_stat,
  input  logic               bus_active,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_EVT-1:0] mask,
  output logic               en_req,
  output logic [NUM_EVT-1:0] clr_vec,
  output logic               abrt_clr
);

  logic [NUM_EVT-1:0] mask_q;
  logic               en_q;
  logic               mask_we;
  logic               en_we;
  logic               clr_all;
  logic [NUM_EVT-1:0] clr_one;

  assign mask_we = wr && (addr == A_MASK);
  assign en_we   = wr && (addr == A_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wdata[NUM_EVT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_we) en_q <= wdata[0];
  end

  // per-event clear-on-read decode
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_clr
    assign clr_one[i] = rd && (addr == ADDR_W'(A_CLR_BASE + 4 * i));
  end

  assign clr_all  = rd && (addr == A_CLR_ALL);
  assign clr_vec  = clr_one | {NUM_EVT{clr_all}};
  assign abrt_clr = clr_one[EV_ABORT];

  always_comb begin
    rdata = '0;
    case (addr)
      A_RAW:     rdata[NUM_EVT-1:0] = raw;
      A_MASK:    rdata[NUM_EVT-1:0] = mask_q;
      A_STAT:    rdata[NUM_EVT-1:0] = raw & mask_q;
      A_CLR_ALL: rdata[0]           = |(raw & ~LEVEL_MASK);
      A_ABRT:    rdata[NUM_EVT-1:0] = abrt;
      A_EN:      rdata[0]           = en_q;
      A_EN_ST:   rdata[0]           = en_stat;
      A_BUS:     rdata[0]           = bus_active;
      A_ID:      rdata              = COMP_ID;
      default: begin
        for (int i = 0; i < NUM_EVT; i++) begin
          if (addr == ADDR_W'(A_CLR_BASE + 4 * i)) rdata[0] = raw[i];
        end
      end
    endcase
  end

  assign mask   = mask_q;
  assign en_req = en_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:NUM_EVT];

endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int DRAIN_MAX = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [NUM_EVT-1:0] abrt_cause,
  input  logic               bus_active,
  input  logic               byte_busy,
  output logic               ctl_enabled,
  output logic               irq
);

  logic [NUM_EVT-1:0] raw_w;
  logic [NUM_EVT-1:0] mask_w;
  logic [NUM_EVT-1:0] abrt_w;
  logic [NUM_EVT-1:0] clr_w;
  logic               abrt_clr_w;
  logic               en_req_w;
  logic               en_stat_w;

  i2c_irq_evt_bank #(.N(NUM_EVT), .LVL(LEVEL_MASK)) u_evt (
    .clk (clk),
    .rst_n (rst_n),
    .src (evt_in),
    .clr (clr_w),
    .raw (raw_w)
  );

  i2c_irq_abort_rec #(.N(NUM_EVT), .VALID(ABRT_VALID)) u_abrt (
    .clk (clk),
    .rst_n (rst_n),
    .capture (evt_in[EV_ABORT]),
    .cause (abrt_cause),
    .clr (abrt_clr_w),
    .src (abrt_w)
  );

  i2c_irq_en_ctrl #(.DRAIN_MAX(DRAIN_MAX)) u_en (
    .clk (clk),
    .rst_n (rst_n),
    .en_req (en_req_w),
    .byte_busy (byte_busy),
    .en_stat (en_stat_w)
  );

  i2c_irq_regif u_reg (
    .clk (clk),
    .rst_n (rst_n),
    .addr (reg_addr),
    .rd (reg_rd),
    .wr (reg_wr),
    .wdata (reg_wdata),
    .raw (raw_w),
    .abrt (abrt_w),
    .en_stat (en_stat_w),
    .bus_active (bus_active),
    .rdata (reg_rdata),
    .mask (mask_w),
    .en_req (en_req_w),
    .clr_vec (clr_w),
    .abrt_clr (abrt_clr_w)
  );

  assign irq         = |(raw_w & mask_w);
  assign ctl_enabled = en_stat_w;

endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk
  import i2c_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_rd,
  input logic [NUM_EVT-1:0] evt_in,
  input logic [NUM_EVT-1:0] raw,
  input logic [NUM_EVT-1:0] abrt,
  input logic               en_req,
  input logic               en_stat
);

  localparam logic [ADDR_W-1:0] CLR_STOP = ADDR_W'(A_CLR_BASE + 4 * EV_STOP);
  localparam logic [ADDR_W-1:0] CLR_ABRT = ADDR_W'(A_CLR_BASE + 4 * EV_ABORT);

  // R2
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_in[EV_STOP] |=> raw[EV_STOP]);

  // R4
  single_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == CLR_STOP && !evt_in[EV_STOP]) |=> !raw[EV_STOP]);

  // R4
  neighbour_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == CLR_STOP && !evt_in[EV_START])
      |=> raw[EV_START] == $past(raw[EV_START]));

  // R7
  abrt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CLR_ALL && !evt_in[EV_ABORT]) |=> abrt == $past(abrt));

  // R7
  abrt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == CLR_ABRT && !evt_in[EV_ABORT]) |=> abrt == '0);

  // R8
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_stat) |-> $past(en_req));

  // R9
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_stat) |-> !$past(en_req));

endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .reg_addr (reg_addr),
  .reg_rd (reg_rd),
  .evt_in (evt_in),
  .raw (raw_w),
  .abrt (abrt_w),
  .en_req (en_req_w),
  .en_stat (en_stat_w)
);

// File: tb/i2c_irq_ctrl_tb_top.sv
module i2c_irq_ctrl_tb_top;

  localparam int DRAIN = 16;

  logic        clk;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_rd;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [11:0] evt_in;
  logic [11:0] abrt_cause;
  logic        bus_active;
  logic        byte_busy;
  logic        ctl_enabled;
  logic        irq;

  i2c_irq_ctrl #(.DRAIN_MAX(DRAIN)) dut_i (
    .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_rd (reg_rd),
    .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .evt_in (evt_in), .abrt_cause (abrt_cause), .bus_active (bus_active),
    .byte_busy (byte_busy), .ctl_enabled (ctl_enabled), .irq (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [11:0] m_stk;
  logic [11:0] m_mask;
  logic [11:0] m_abrt;
  bit          m_en;
  bit          m_ens;
  int          m_cnt;

  localparam logic [11:0] LVL   = 12'h014;
  localparam logic [11:0] VALID = 12'hEBF;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R1";
      8'h04, 8'h08: return "R3";
      8'h0C: return "R5";
      8'h10: return "R6";
      8'h14: return "R8";
      8'h18: return "R9";
      8'h1C, 8'h20: return "R10";
      default: return (a >= 8'h40 && a < 8'h70 && a[1:0] == 2'b00) ? "R4" : "R11";
    endcase
  endfunction

  function automatic logic [11:0] exp_raw();
    return m_stk | (evt_in & LVL);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [11:0] r;
    r = exp_raw();
    case (a)
      8'h00: return {20'b0, r};
      8'h04: return {20'b0, m_mask};
      8'h08: return {20'b0, r & m_mask};
      8'h0C: return {31'b0, |m_stk};
      8'h10: return {20'b0, m_abrt};
      8'h14: return {31'b0, m_en};
      8'h18: return {31'b0, m_ens};
      8'h1C: return {31'b0, bus_active};
      8'h20: return 32'h44570140;
      default: begin
        for (int i = 0; i < 12; i++)
          if (a == 8'(64 + 4 * i)) return {31'b0, r[i]};
        return 32'h0;
      end
    endcase
  endfunction

  task automatic model_update();
    bit clr_all;
    bit old_en;
    clr_all = reg_rd && reg_addr == 8'h0C;
    for (int i = 0; i < 12; i++) begin
      if (!LVL[i]) begin
        if (evt_in[i]) m_stk[i] = 1'b1;
        else if (clr_all || (reg_rd && reg_addr == 8'(64 + 4 * i))) m_stk[i] = 1'b0;
      end
    end
    if (reg_rd && reg_addr == 8'h58)
      m_abrt = evt_in[6] ? (abrt_cause & VALID) : 12'h0;
    else if (evt_in[6])
      m_abrt = m_abrt | (abrt_cause & VALID);
    old_en = m_en;
    if (old_en && !m_ens) begin
      m_ens = 1; m_cnt = 0;
    end else if (!old_en && m_ens) begin
      if (!byte_busy || m_cnt == DRAIN - 1) begin m_ens = 0; m_cnt = 0; end
      else m_cnt++;
    end else m_cnt = 0;
    if (reg_wr && reg_addr == 8'h04) m_mask = reg_wdata[11:0];
    if (reg_wr && reg_addr == 8'h14) m_en = reg_wdata[0];
  endtask

  // one clock: compare at negedge+1, then advance the model at the edge
  task automatic step(input string tag);
    logic [11:0] r;
    #1;
    r = exp_raw();
    chk((tag != "") ? tag : tag_of(reg_addr), "rdata", reg_rdata, exp_read(reg_addr));
    chk("R3", "irq", {31'b0, irq}, {31'b0, |(r & m_mask)});
    chk("R8,R9", "ctl_enabled", {31'b0, ctl_enabled}, {31'b0, m_ens});
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic rd_(input logic [7:0] a, input string tag);
    reg_addr = a; reg_rd = 1; step(tag); reg_rd = 0;
  endtask

  task automatic wr_(input logic [7:0] a, input logic [31:0] d, input string tag);
    reg_addr = a; reg_wr = 1; reg_wdata = d; step(tag); reg_wr = 0;
  endtask

  task automatic pulse_(input logic [11:0] v, input logic [11:0] c);
    logic [11:0] hold;
    hold = evt_in & LVL;
    evt_in = v | hold; abrt_cause = c; step("R2");
    evt_in = hold; abrt_cause = 0;
  endtask

  initial begin
    rst_n = 0; reg_addr = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
    evt_in = 0; abrt_cause = 0; bus_active = 0; byte_busy = 0;
    m_stk = 0; m_mask = 0; m_abrt = 0; m_en = 0; m_ens = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset raw", reg_rdata, 32'h0);
    chk("R3", "reset irq", {31'b0, irq}, 32'h0);
    chk("R8", "reset enabled", {31'b0, ctl_enabled}, 32'h0);
    @(negedge clk);
    rst_n = 1;

    // R10 identity and bus activity
    rd_(8'h20, "R10");
    bus_active = 1; rd_(8'h1C, "R10");
    bus_active = 0; rd_(8'h1C, "R10");

    // R2 each sticky event, one at a time
    for (int i = 0; i < 12; i++) begin
      if (!LVL[i]) begin
        pulse_(12'(1 << i), 12'h0);
        rd_(8'h00, "R2");
      end
    end

    // R1 level bits follow inputs and survive their clear reads
    evt_in[2] = 1; rd_(8'h00, "R1");
    rd_(8'h48, "R1"); rd_(8'h00, "R1");
    evt_in[4] = 1; rd_(8'h50, "R1"); rd_(8'h0C, "R1"); rd_(8'h00, "R1");
    evt_in[2] = 0; evt_in[4] = 0; rd_(8'h00, "R1");

    // R3 mask and irq
    for (int i = 0; i < 12; i++) pulse_(12'(1 << i) & ~LVL, 12'h0);
    wr_(8'h04, 32'h200, "R3"); rd_(8'h08, "R3");
    // R4 single clear of stop
    rd_(8'h64, "R4"); rd_(8'h00, "R4"); rd_(8'h08, "R3");
    // R2 set wins over same-cycle clear of start
    evt_in[10] = 1; reg_addr = 8'h68; reg_rd = 1; step("R2");
    reg_rd = 0; evt_in[10] = 0; rd_(8'h00, "R2");

    // R6 abort capture with reserved bits driven
    pulse_(12'h040, 12'hFFF); rd_(8'h10, "R6");
    // R7 global clear keeps abort cause
    rd_(8'h0C, "R5"); rd_(8'h10, "R7"); rd_(8'h00, "R5");
    rd_(8'h58, "R7"); rd_(8'h10, "R7");
    // R7 capture in same cycle as abort clear is kept
    pulse_(12'h040, 12'h009);
    evt_in[6] = 1; abrt_cause = 12'h800; reg_addr = 8'h58; reg_rd = 1; step("R7");
    reg_rd = 0; evt_in[6] = 0; abrt_cause = 0; rd_(8'h10, "R7");

    // R8 / R9 enable handshake
    wr_(8'h14, 32'h1, "R8"); rd_(8'h18, "R8"); rd_(8'h18, "R8");
    wr_(8'h14, 32'h0, "R9"); rd_(8'h18, "R9"); rd_(8'h18, "R9");
    wr_(8'h14, 32'h1, "R8"); rd_(8'h18, "R8");
    byte_busy = 1; wr_(8'h14, 32'h0, "R9");
    repeat (DRAIN + 3) rd_(8'h18, "R9");
    byte_busy = 0;
    wr_(8'h14, 32'h1, "R8"); rd_(8'h18, "R8");
    byte_busy = 1; wr_(8'h14, 32'h0, "R9");
    repeat (5) rd_(8'h18, "R9");
    byte_busy = 0; repeat (3) rd_(8'h18, "R9");

    // R11 side-effect-free reads, ignored writes, unmapped reads
    pulse_(12'h3AB, 12'h0);
    repeat (3) rd_(8'h00, "R11");
    wr_(8'h00, 32'hFFFF_FFFF, "R11"); wr_(8'h10, 32'hFFF, "R11");
    rd_(8'h3C, "R11"); rd_(8'h44, "R11"); rd_(8'h00, "R11"); rd_(8'h10, "R11");

    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      logic [7:0] picks [16];
      picks = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
                8'h40, 8'h44, 8'h58, 8'h5C, 8'h60, 8'h64, 8'h68, 8'h6C};
      reg_addr   = picks[$urandom % 16];
      reg_rd     = ($urandom % 3) == 0;
      reg_wr     = ($urandom % 6) == 0;
      reg_wdata  = $urandom;
      evt_in     = 12'($urandom & $urandom & $urandom);
      abrt_cause = 12'($urandom);
      bus_active = $urandom % 2;
      byte_busy  = ($urandom % 4) != 0;
      step("");
    end
    reg_rd = 0; reg_wr = 0; evt_in = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule